// File: doc/BRIEF.md
# Processor Run-Rate Controller

This block decides when a processor core is allowed to advance. A two-bit rate selector chooses one of three ways of running: free running, one whole instruction per start press, or one minimum clock step per start press. Start and stop pushbuttons arrive as level inputs. The block detects their rising edges, so one press makes exactly one request.

The instruction sequencer sits outside the block. Each cycle it reports two things: whether the current clock finishes an instruction, and whether an I/O operation is in its asynchronous phase. The block returns a run/stopped state and a per-clock advance enable. It also gates the interval-timer tick and lights a test indicator whenever the selector is off the free-running position.

A stop press during free running does not halt the core in mid-instruction. It lets the current instruction finish. This gives the same stop point as an instruction step. In single-cycle mode, the press that finds an I/O operation in its asynchronous phase runs that phase to its end.

Top module: `run_rate_ctrl`

## Requirements
- R1: Selector encoding is 2'b00 free run, 2'b01 instruction step, 2'b10 and 2'b11 single cycle. `testLight` is 1 exactly when the selector is not 2'b00.
- R2: After reset the block is stopped, with `running` and `advanceEn` both 0.
- R3: In free-run mode a start press makes `running` and `advanceEn` 1 from the next cycle on, every cycle, until a stop takes effect. `instrDone` does not end a free run.
- R4: In instruction-step mode a start press advances the core from the next cycle up to and including the cycle in which `instrDone` is 1. The block is stopped in the cycle after that.
- R5: A stop press during a free run keeps the core advancing until a cycle with `instrDone` at 1 and then stops. If `instrDone` is 1 in the cycle of the press, the next cycle is already stopped.
- R6: In single-cycle mode with `ioAsync` at 0, each start press gives exactly one cycle with `advanceEn` at 1.
- R7: In single-cycle mode, a start press while `ioAsync` is 1 keeps the core advancing until a cycle in which `ioAsync` is 0. A stop press does not end this run.
- R8: `timerIncEn` follows `timerTick` in the same cycle, except while the selector is 2'b01, when it stays 0.
- R9: A change of the selector while running does not alter the current run.
- R10: A start button held high over many cycles counts as a single press.
- R11: When start and stop rise in the same cycle while stopped, no run begins.
- R12: A start press while already running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateSel | input | 2 | Rate selector position |
| startBtn | input | 1 | Start pushbutton level |
| stopBtn | input | 1 | Stop pushbutton level |
| instrDone | input | 1 | Current clock completes an instruction |
| ioAsync | input | 1 | I/O operation is in its asynchronous phase |
| timerTick | input | 1 | Raw interval-timer tick |
| running | output | 1 | Processor is in a run (not stopped) |
| advanceEn | output | 1 | Processor may advance this clock |
| timerIncEn | output | 1 | Gated interval-timer increment |
| testLight | output | 1 | Selector is off the free-run position |

## Verification
The assertions assume that the sequencer raises `instrDone` only in cycles where the core advances. They also assume that the start and stop buttons are synchronous levels sampled at the clock. The checker keeps its own copy of the last start level, so it can tell a fresh press apart from a held button. The stimulus pulses `instrDone` only while `advanceEn` is 1, and it drives every input on the falling edge. Asynchronous I/O phases are modelled by holding `ioAsync` high for a bounded stretch and then dropping it.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_FREE  = 2'b00;
  localparam logic [SEL_W-1:0] SEL_ISTEP = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FREE, ST_TOEND, ST_CYCLE, ST_ASYNC
  } runState_t;

  typedef struct packed {
    logic startPress;
    logic stopPress;
  } btnEvent_t;

  typedef struct packed {
    logic running;
    logic advance;
  } ctlStrobe_t;
endpackage

// File: rtl/rrc_datapath.sv
module rrc_datapath
  import rrc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] rateSel,
  input  logic             startBtn,
  input  logic             stopBtn,
  input  logic             timerTick,
  input  ctlStrobe_t       strobe,
  output btnEvent_t        events,
  output logic             running,
  output logic             advanceEn,
  output logic             timerIncEn,
  output logic             testLight
);
  logic startQ, stopQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      stopQ  <= 1'b0;
    end else begin
      startQ <= startBtn;
      stopQ  <= stopBtn;
    end
  end

  always_comb begin
    events.startPress = startBtn && !startQ;
    events.stopPress  = stopBtn && !stopQ;
    running    = strobe.running;
    advanceEn  = strobe.advance;
    timerIncEn = timerTick && (rateSel != SEL_ISTEP);
    testLight  = (rateSel != SEL_FREE);
  end
endmodule

// File: rtl/rrc_control.sv
module rrc_control
  import rrc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] rateSel,
  input  logic             instrDone,
  input  logic             ioAsync,
  input  btnEvent_t        events,
  output ctlStrobe_t       strobe
);
  runState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (events.startPress && !events.stopPress) begin
          if (rateSel == SEL_FREE)       nextState = ST_FREE;
          else if (rateSel == SEL_ISTEP) nextState = ST_TOEND;
          else if (ioAsync)              nextState = ST_ASYNC;
          else                           nextState = ST_CYCLE;
        end
      end
      ST_FREE: begin
        if (events.stopPress) nextState = instrDone ? ST_IDLE : ST_TOEND;
      end
      ST_TOEND: begin
        if (instrDone) nextState = ST_IDLE;
      end
      ST_CYCLE: nextState = ST_IDLE;
      ST_ASYNC: begin
        if (!ioAsync) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.running = (state != ST_IDLE);
    strobe.advance = (state != ST_IDLE);
  end
endmodule

// File: rtl/run_rate_ctrl.sv
module run_rate_ctrl
  import rrc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] rateSel,
  input  logic             startBtn,
  input  logic             stopBtn,
  input  logic             instrDone,
  input  logic             ioAsync,
  input  logic             timerTick,
  output logic             running,
  output logic             advanceEn,
  output logic             timerIncEn,
  output logic             testLight
);
  btnEvent_t  events;
  ctlStrobe_t strobe;

  rrc_datapath u_dp (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .startBtn(startBtn),
    .stopBtn(stopBtn), .timerTick(timerTick), .strobe(strobe),
    .events(events), .running(running), .advanceEn(advanceEn),
    .timerIncEn(timerIncEn), .testLight(testLight)
  );

  rrc_control u_ctl (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .instrDone(instrDone),
    .ioAsync(ioAsync), .events(events), .strobe(strobe)
  );
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] rateSel,
  input logic       startBtn,
  input logic       stopBtn,
  input logic       ioAsync,
  input logic       timerTick,
  input logic       running,
  input logic       timerIncEn,
  input logic       testLight
);
  logic startSeen, stopSeen;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else begin
      startSeen <= startBtn;
      stopSeen  <= stopBtn;
    end
  end

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel == 2'b01) |-> !timerIncEn); // R8
  AST_TEST_LIGHT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel == 2'b00) |-> !testLight); // R1
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (!running && startBtn && !startSeen && stopBtn && !stopSeen) |=> !running); // R11
  AST_HELD_START: assert property (@(posedge clk) disable iff (!rstN)
    (!running && startBtn && startSeen) |=> !running); // R10
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (!running && startBtn && !startSeen && !(stopBtn && !stopSeen) && rateSel[1] && !ioAsync)
      |=> running ##1 !running); // R6
  AST_TICK_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (timerTick && rateSel != 2'b01) |-> timerIncEn); // R8
endmodule

bind run_rate_ctrl rrc_checker u_rrc_chk (
  .clk(clk), .rstN(rstN), .rateSel(rateSel), .startBtn(startBtn),
  .stopBtn(stopBtn), .ioAsync(ioAsync), .timerTick(timerTick),
  .running(running), .timerIncEn(timerIncEn), .testLight(testLight)
);

// File: tb/tb_run_rate_ctrl.sv
`timescale 1ns/1ps
module tb_run_rate_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] rateSel = 2'b00;
  logic startBtn = 0, stopBtn = 0, instrDone = 0, ioAsync = 0, timerTick = 0;
  logic running, advanceEn, timerIncEn, testLight;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  run_rate_ctrl dut (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .startBtn(startBtn),
    .stopBtn(stopBtn), .instrDone(instrDone), .ioAsync(ioAsync),
    .timerTick(timerTick), .running(running), .advanceEn(advanceEn),
    .timerIncEn(timerIncEn), .testLight(testLight)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pressStart();
    @(negedge clk) startBtn = 1;
    @(negedge clk) startBtn = 0;
  endtask

  task automatic pressStop();
    @(negedge clk) stopBtn = 1;
    @(negedge clk) stopBtn = 0;
  endtask

  task automatic countAdvance(input int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      if (advanceEn) n++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    check(!running && !advanceEn, "R2 reset stopped", running, 0);
  endtask

  task automatic testLightAll();
    for (int s = 0; s < 4; s++) begin
      @(negedge clk) rateSel = 2'(s);
      #0.5 check(testLight == (s != 0), "R1 test light", testLight, s != 0);
    end
  endtask

  task automatic testTimer();
    @(negedge clk) timerTick = 1; rateSel = 2'b01;
    #0.5 check(timerIncEn == 0, "R8 timer frozen in istep", timerIncEn, 0);
    rateSel = 2'b00;
    #0.5 check(timerIncEn == 1, "R8 timer passes in free run", timerIncEn, 1);
    rateSel = 2'b10;
    #0.5 check(timerIncEn == 1, "R8 timer passes in single cycle", timerIncEn, 1);
    timerTick = 0;
    #0.5 check(timerIncEn == 0, "R8 no tick no inc", timerIncEn, 0);
  endtask

  task automatic testCycle();
    int n;
    @(negedge clk) rateSel = 2'b10; ioAsync = 0;
    for (int k = 0; k < 2; k++) begin
      pressStart();
      countAdvance(8, n);
      check(n == 1, "R6 one advance per press", n, 1);
    end
    @(negedge clk) rateSel = 2'b11;
    pressStart();
    countAdvance(8, n);
    check(n == 1, "R6 alternate code single cycle", n, 1);
  endtask

  task automatic testHeld();
    int n;
    @(negedge clk) rateSel = 2'b10; startBtn = 1;
    @(negedge clk);
    countAdvance(10, n);
    startBtn = 0;
    check(n == 1, "R10 held start single step", n, 1);
    @(negedge clk);
  endtask

  task automatic testIstep(input int len);
    int n = 0;
    @(negedge clk) rateSel = 2'b01;
    pressStart();
    for (int i = 0; i < 30; i++) begin
      if (advanceEn) begin
        instrDone = (n == len - 1);
        n++;
      end else instrDone = 0;
      @(negedge clk);
    end
    instrDone = 0;
    check(n == len, "R4 instruction step length", n, len);
    check(!running, "R4 stopped after step", running, 0);
  endtask

  task automatic testFree();
    int n;
    @(negedge clk) rateSel = 2'b00;
    pressStart();
    instrDone = 1;
    countAdvance(10, n);
    instrDone = 0;
    check(n == 10, "R3 free run advances every cycle", n, 10);
    rateSel = 2'b01;
    countAdvance(5, n);
    check(n == 5, "R9 selector change ignored", n, 5);
    pressStart();
    check(running == 1, "R12 start while running", running, 1);
    pressStop();
    countAdvance(4, n);
    check(n == 4, "R5 keeps running to instruction end", n, 4);
    instrDone = 1;
    @(negedge clk) instrDone = 0;
    check(!running, "R5 stop at instruction end", running, 0);
    @(negedge clk) rateSel = 2'b00;
    pressStart();
    @(negedge clk) stopBtn = 1; instrDone = 1;
    @(negedge clk) stopBtn = 0; instrDone = 0;
    check(!running, "R5 stop with done same cycle", running, 0);
  endtask

  task automatic testPriority();
    int n;
    @(negedge clk) rateSel = 2'b00; startBtn = 1; stopBtn = 1;
    @(negedge clk) startBtn = 0; stopBtn = 0;
    countAdvance(4, n);
    check(n == 0, "R11 stop beats start", n, 0);
  endtask

  task automatic testAsync();
    int n;
    @(negedge clk) rateSel = 2'b10; ioAsync = 1;
    pressStart();
    countAdvance(3, n);
    pressStop();
    check(running == 1, "R7 stop ignored in async phase", running, 1);
    ioAsync = 0;
    @(negedge clk);
    check(!running, "R7 stops when async ends", running, 0);
    check(n == 3, "R7 async run advances", n, 3);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testLightAll();
    testTimer();
    testCycle();
    testHeld();
    testIstep(3);
    testIstep(1);
    testFree();
    testPriority();
    testAsync();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule